// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO Controller

This block is a first-in, first-out buffer with a write clock and a read clock that run freely. The two clocks may be unrelated or may be the same net. Words enter on the write side when both write enables are high and the input-ready flag is high. Each pointer is kept in binary and also in a Gray-coded copy. The Gray copy crosses into the other clock domain through a two-stage synchroniser, and full and empty are judged there. The output register is loaded without any request: once a word reaches an empty buffer, it moves into the held output register by itself and output-ready goes high. A read request then hands over the next word. When the buffer runs dry the register keeps the last word.

The write side is a state machine with states `WR_RESET`, `WR_READY` and `WR_FULL`. The transitions are: **release** (WR_RESET to WR_READY, one write edge after reset is released), **fill** (WR_READY to WR_FULL on the write that takes up the last free place) and **drain** (WR_FULL to WR_READY once the synchronised read pointer shows free space). The read side has states `RD_RESET`, `RD_EMPTY` and `RD_VALID`. Its transitions are: **release** (RD_RESET to RD_EMPTY), **fall-through** (RD_EMPTY to RD_VALID when the synchronised write pointer shows data) and **dry** (RD_VALID to RD_EMPTY when a read consumes the held word and no further word is present).

The output enable gates reads. It also drives a valid indicator that stands in for a high-impedance output stage. The memory depth is 2^ADDR_W words, and the output register adds one more place, so the total capacity is 2^ADDR_W + 1 words.

Top module: `dcfifo_ft`

## Requirements
- R1: Words leave on `rd_data` unaltered and in the order in which they were written. The total capacity is 2^ADDR_W + 1 words: 2^ADDR_W in memory plus 1 in the output register.
- R2: A write happens on a `wclk` rising edge only when `wr_en_a`, `wr_en_b` and `in_rdy` are all high. With either enable low, nothing is stored.
- R3: The held word is consumed on a `rclk` rising edge only when `rd_en_a`, `rd_en_b`, `out_en` and `out_rdy` are all high. Otherwise `rd_data` and `out_rdy` are unchanged.
- R4: When a word is written into an empty buffer, it appears on `rd_data` and `out_rdy` rises on the third `rclk` rising edge after the write edge, whatever the read enables and `out_en` are doing. With coincident clocks, this is the third edge after the write.
- R5: While `out_rdy` is low, `rd_data` keeps the last word that was read.
- R6: `rst_n` is active low and asynchronous. While it is low, `in_rdy` and `out_rdy` are low. `in_rdy` rises on the second `wclk` rising edge after release.
- R7: `in_rdy` falls on the write edge that brings the stored count to 2^ADDR_W + 1. While it is low, writes are ignored.
- R8: With coincident clocks, after a read from a full buffer, `in_rdy` rises on the fourth edge counted from the read edge, and not earlier.
- R9: `out_vld` equals `out_en`: high means the data output is driven, low means it is notionally high-impedance.
- R10: With unrelated clock periods and irregular enables on both sides, every written word is read back exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | DATA_W | Write data |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| in_rdy | output | 1 | Input-ready flag, write domain |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable, qualifies reads |
| rd_data | output | DATA_W | Held output word |
| out_rdy | output | 1 | Output-ready flag, read domain |
| out_vld | output | 1 | Output driven (low stands for high-Z) |

## Verification
The bench targets the exact fall-through latency. A design that skipped or added a synchroniser stage would raise `out_rdy` one edge too early or too late. The bench fills the buffer to exactly one word beyond the memory depth: a design that did not count the output register as storage would drop `in_rdy` one write too soon, and one with an off-by-one full compare would overwrite unread data. It holds each read qualifier low in turn and drains the buffer past empty, which exposes designs that advance on a partial enable or that clear the held word. Two runs with unrelated clock periods, one where the reader is slower than the writer and one where it is faster, push the buffer repeatedly against full and then against empty; a Gray-code or pointer-wrap fault would show up there as lost, repeated or reordered words.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic [1:0] {WR_RESET, WR_READY, WR_FULL} wr_state_e;
    typedef enum logic [1:0] {RD_RESET, RD_EMPTY, RD_VALID} rd_state_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DW = 9,
    parameter int AW = 11
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;
    logic [DW-1:0] store [WORDS];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_a,
    input  logic        en_b,
    input  logic [AW:0] rd_gray_s,
    output logic        ir,
    output logic        fire,
    output logic [AW-1:0] addr,
    output logic [AW:0] gray
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_GAP = {1'b1, {AW{1'b0}}};

    wr_state_e state, state_nx;
    logic          rel;
    logic [PW-1:0] bin, bin_nx, rbin;
    logic          full_now, full_after;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rd_gray_s >> i);
    end

    assign fire       = (state == WR_READY) && en_a && en_b;
    assign bin_nx     = bin + PW'(fire);
    assign full_now   = (bin - rbin) == FULL_GAP;
    assign full_after = (bin_nx - rbin) == FULL_GAP;
    assign addr       = bin[AW-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_RESET: if (rel)        state_nx = WR_READY;
            WR_READY: if (full_after) state_nx = WR_FULL;
            WR_FULL:  if (!full_now)  state_nx = WR_READY;
            default:                  state_nx = WR_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_RESET;
            rel   <= 1'b0;
        end else begin
            state <= state_nx;
            rel   <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end

    always_comb ir = (state == WR_READY);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_a,
    input  logic          en_b,
    input  logic          oe,
    input  logic [AW:0]   wr_gray_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] addr,
    output logic [AW:0]   gray,
    output logic [DW-1:0] dout,
    output logic          or_o
);
    localparam int PW = AW + 1;

    rd_state_e state, state_nx;
    logic          rel;
    logic [PW-1:0] bin, wbin;
    logic          avail, take, load;

    always_comb begin
        for (int i = 0; i < PW; i++) wbin[i] = ^(wr_gray_s >> i);
    end

    assign avail = bin != wbin;
    assign take  = (state == RD_VALID) && en_a && en_b && oe;
    assign load  = ((state == RD_EMPTY) || take) && avail;
    assign addr  = bin[AW-1:0];

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_RESET: if (rel)            state_nx = RD_EMPTY;
            RD_EMPTY: if (avail)          state_nx = RD_VALID;
            RD_VALID: if (take && !avail) state_nx = RD_EMPTY;
            default:                      state_nx = RD_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_RESET;
            rel   <= 1'b0;
        end else begin
            state <= state_nx;
            rel   <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
            dout <= '0;
        end else if (load) begin
            bin  <= bin + 1'b1;
            gray <= (bin + 1'b1) ^ ((bin + 1'b1) >> 1);
            dout <= mem_rdata;
        end
    end

    always_comb or_o = (state == RD_VALID);
endmodule

// File: rtl/dcfifo_ft.sv
module dcfifo_ft #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 11
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    output logic              in_rdy,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_rdy,
    output logic              out_vld
);
    localparam int PW = ADDR_W + 1;

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
    logic [DATA_W-1:0] mem_q;

    dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
        .clk(wclk), .rst_n(rst_n), .en_a(wr_en_a), .en_b(wr_en_b),
        .rd_gray_s(rd_gray_s), .ir(in_rdy), .fire(wr_fire),
        .addr(wr_addr), .gray(wr_gray)
    );

    dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));
    dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));

    dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .wclk(wclk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(mem_q)
    );

    dcf_rd_ctl #(.AW(ADDR_W), .DW(DATA_W)) u_rd (
        .clk(rclk), .rst_n(rst_n), .en_a(rd_en_a), .en_b(rd_en_b), .oe(out_en),
        .wr_gray_s(wr_gray_s), .mem_rdata(mem_q), .addr(rd_addr),
        .gray(rd_gray), .dout(rd_data), .or_o(out_rdy)
    );

    assign out_vld = out_en;
endmodule

// File: rtl/dcfifo_ft_chk.sv
module dcfifo_ft_chk #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 11
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              wr_en_a,
    input logic              wr_en_b,
    input logic              in_rdy,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic              out_en,
    input logic              out_rdy,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   wr_gray
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (!rst_n)
        !in_rdy |=> $stable(wr_gray)); // R7

    AST_WRITE_NEEDS_BOTH: assert property (@(posedge wclk) disable iff (!rst_n)
        !(wr_en_a && wr_en_b) |=> $stable(wr_gray)); // R2

    AST_READ_NEEDS_ALL: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_rdy && !(rd_en_a && rd_en_b && out_en)) |=> ($stable(rd_data) && out_rdy)); // R3

    AST_HOLD_WHILE_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
        !out_rdy |=> (out_rdy || $stable(rd_data))); // R5

    AST_IR_LOW_AT_RELEASE: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(rst_n) |-> !in_rdy); // R6

    AST_OR_LOW_AT_RELEASE: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_rdy); // R6
endmodule

bind dcfifo_ft dcfifo_ft_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_dcfifo_ft.sv
module test_dcfifo_ft;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 9;
    localparam int AW = 3;
    localparam int NW = 200;

    logic wclk = 1'b0, rclk_s = 1'b0, async_mode = 1'b0;
    real  rhalf = 3.0;
    logic rclk;
    assign rclk = async_mode ? rclk_s : wclk;
    always #2 wclk = ~wclk;
    always #(rhalf) rclk_s = ~rclk_s;

    logic rst_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic wr_en_a = 0, wr_en_b = 0, rd_en_a = 0, rd_en_b = 0, out_en = 0;
    logic in_rdy, out_rdy, out_vld;
    logic [DW-1:0] rd_data;

    dcfifo_ft #(.DATA_W(DW), .ADDR_W(AW)) i_dcfifo_ft (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .in_rdy(in_rdy),
        .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
        .rd_data(rd_data), .out_rdy(out_rdy), .out_vld(out_vld)
    );

    int  nchk = 0, nfail = 0;
    bit  done = 0;
    logic [DW-1:0] exp_q [512];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge wclk);
        @(negedge wclk);
    endtask

    function automatic logic [DW-1:0] wv(input int k);
        return DW'((k * 37 + 5) % 512);
    endfunction

    task automatic wr_on(input logic on);
        wr_en_a = on;
        wr_en_b = on;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (5) tick();
        check("R6 ir in reset", in_rdy, 0);
        check("R6 or in reset", out_rdy, 0);
        rst_n = 1'b1;
        tick();
        check("R6 ir first edge", in_rdy, 0);
        tick();
        check("R6 ir second edge", in_rdy, 1);

        // R2: one enable low at a time, nothing may reach the output
        wr_data = 9'h155; wr_en_a = 1; wr_en_b = 0;
        tick(); tick();
        wr_en_a = 0; wr_en_b = 1;
        tick();
        wr_en_b = 0;
        repeat (4) tick();
        check("R2 partial enable stores nothing", out_rdy, 0);

        // R4: fall-through latency
        wr_data = wv(1); wr_on(1);
        tick();
        wr_on(0);
        check("R4 or after write edge", out_rdy, 0);
        tick();
        check("R4 or edge 1", out_rdy, 0);
        tick();
        check("R4 or edge 2", out_rdy, 0);
        tick();
        check("R4 or edge 3", out_rdy, 1);
        check("R4 data edge 3", rd_data, wv(1));

        check("R9 vld off", out_vld, 0);
        out_en = 1; #1;
        check("R9 vld on", out_vld, 1);
        out_en = 0;
        repeat (4) tick();

        // R7: fill memory plus output register
        for (int k = 2; k <= 9; k++) begin
            wr_data = wv(k); wr_on(1);
            tick();
            check("R7 ir during fill", in_rdy, (k < 9) ? 1 : 0);
        end
        wr_data = 9'h0FF;
        tick(); tick();
        wr_on(0);
        check("R7 ir stays low", in_rdy, 0);
        check("R7 held word", rd_data, wv(1));

        // R3: partial read qualifiers
        rd_en_a = 1; rd_en_b = 1; out_en = 0;
        tick(); tick();
        check("R3 oe low no read", rd_data, wv(1));
        out_en = 1; rd_en_b = 0;
        tick(); tick();
        check("R3 en_b low no read", rd_data, wv(1));
        check("R3 or kept", out_rdy, 1);

        // R1/R5/R8: drain
        rd_en_b = 1;
        for (int k = 1; k <= 9; k++) begin
            tick();
            if (k <= 8) begin
                check("R1 order", rd_data, wv(k + 1));
                check("R1 or during drain", out_rdy, 1);
            end else begin
                check("R5 or empty", out_rdy, 0);
                check("R5 last word held", rd_data, wv(9));
            end
            if (k == 3) check("R8 ir not yet", in_rdy, 0);
            if (k == 4) check("R8 ir back", in_rdy, 1);
        end
        repeat (3) tick();
        check("R5 held after idle", rd_data, wv(9));
        check("R7 ignored write absent", out_rdy, 0);

        // R4 again with read enables held high
        wr_data = wv(10); wr_on(1);
        tick();
        wr_on(0);
        tick(); tick();
        check("R4 or edge 2 enables high", out_rdy, 0);
        tick();
        check("R4 or edge 3 enables high", out_rdy, 1);
        check("R4 data enables high", rd_data, wv(10));
        tick();
        check("R5 dry again", out_rdy, 0);
        check("R5 keep word", rd_data, wv(10));
        rd_en_a = 0; rd_en_b = 0; out_en = 0;

        // R10: unrelated clocks, slow then fast reader
        for (int run = 0; run < 2; run++) begin
            rst_n = 0;
            async_mode = 1;
            rhalf = (run == 0) ? 3.5 : 1.5;
            repeat (5) tick();
            repeat (5) @(posedge rclk);
            @(negedge wclk);
            rst_n = 1;
            repeat (3) tick();
            fork
                begin
                    int wn = 0, cyc = 0;
                    while (wn < NW) begin
                        @(negedge wclk);
                        cyc++;
                        wr_data = DW'((wn * 53 + run * 7 + 11) % 512);
                        wr_on(cyc % 3 != 0);
                        if ((cyc % 3 != 0) && in_rdy) begin
                            exp_q[wn] = wr_data;
                            wn++;
                        end
                    end
                    @(negedge wclk);
                    wr_on(0);
                end
                begin
                    int rn = 0, cyc = 0;
                    while (rn < NW) begin
                        @(negedge rclk);
                        cyc++;
                        rd_en_a = 1; out_en = 1;
                        rd_en_b = (cyc % 4 != 1);
                        if ((cyc % 4 != 1) && out_rdy) begin
                            check("R10 async order", rd_data, exp_q[rn]);
                            rn++;
                        end
                    end
                    @(negedge rclk);
                    rd_en_a = 0; rd_en_b = 0; out_en = 0;
                end
            join
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule